// File: doc/BRIEF.md
# Switching-Cycle Gate Sequencer with Pulse Skipping

This block is the digital switch logic of one current-mode buck channel. It turns a per-cycle start tick and an analog modulator trip into two complementary gate commands, one for the high-side switch and one for the low-side switch. Dead time is adaptive rather than fixed. The high side waits until the low gate is sensed discharged. The low side waits until the switching node is sensed low. Cycle-by-cycle current limits and a zero-crossing cutoff end either conduction interval early.

At light load, when pulse skipping is allowed, the channel enters a skipping state. It then fires only in cycles where feedback is below the reference. A droop on the auxiliary rail cancels skipping for a fixed number of cycle starts. A duty limiter counts clocks from each cycle start and ends the high-side pulse at a fixed fraction of the cycle. That fraction depends on the selected frequency setting. Two supervisor overrides take precedence over everything else: an overvoltage clamp and a halt.

Top module: `pwm_switch_logic`

## Requirements
- R1: After reset, `hs_on`, `ls_on` and `skip_mode` are all 0.
- R2: A cycle start that fires arms a high-side request. `hs_on` rises at the first later clock edge where `lg_low` is 1. While `lg_low` is 0, `hs_on` stays 0.
- R3: When `hs_on` is 1 and `cmp_trip` or `oc_pos` is 1 at a clock edge, `hs_on` is 0 after that edge. A trip that arrives while the request is still waiting cancels the request.
- R4: A position counter is cleared by the cycle start and advances one per clock. The high side is forced off when the count reaches floor(LEN×PCT/100). The default limits are 47 clocks for a 50-clock cycle at 94% (`freq_fast`=1) and 72 clocks for a 75-clock cycle at 96% (`freq_fast`=0). A pulse with no trip therefore lasts exactly that many clocks.
- R5: `ls_on` rises only after the high-side interval of the cycle has ended, at an edge where `phase_low` is 1. It then stays on until the next cycle start.
- R6: `oc_neg` at an edge with `ls_on` high turns the low side off. It stays off for the rest of that cycle.
- R7: `zero_cross` turns the low side off only while skipping is allowed (`psave_n`=0 and no forced interval). Otherwise it has no effect.
- R8: With skipping allowed, a cycle start with `light_load`=1 still fires and sets `skip_mode`. While `skip_mode` is set, a start fires only if `fb_low`=1, and it leaves `skip_mode` if at the same time `light_load`=0. A start while skipping is not allowed clears `skip_mode` and fires.
- R9: An edge with `aux_droop`=1 makes the next 8 cycle starts behave as if skipping were not allowed.
- R10: `ovp_force`=1 (without `halt`) drives `hs_on`=0 and `ls_on`=1 after the edge and clears any request.
- R11: `halt`=1 drives both gate commands to 0 after the edge. It takes priority over `ovp_force`.
- R12: `hs_on` and `ls_on` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-clock tick at the start of each switching cycle |
| freq_fast | input | 1 | 1 = fast frequency setting (94% limit), 0 = slow (96%) |
| cmp_trip | input | 1 | Modulator comparator trip |
| oc_pos | input | 1 | Positive overcurrent |
| oc_neg | input | 1 | Negative overcurrent |
| zero_cross | input | 1 | Inductor current about to reverse |
| light_load | input | 1 | Current below a quarter of peak |
| fb_low | input | 1 | Feedback below reference |
| phase_low | input | 1 | Switching node sensed low |
| lg_low | input | 1 | Low-side gate sensed low |
| psave_n | input | 1 | 0 = pulse skipping allowed |
| aux_droop | input | 1 | Auxiliary rail droop |
| ovp_force | input | 1 | Latched overvoltage override |
| halt | input | 1 | Supervisor halt, both gates off |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |
| skip_mode | output | 1 | Pulse-skipping state |

## Verification
Directed sequences hold one sense flag back at a time. Holding `lg_low` or `phase_low` low shows that each dead-time gate actually waits. A trip-free cycle at each frequency setting separates the two duty limits exactly. A light-load run with feedback high, then low, shows entry into skipping, the skipped cycles and the exit. A droop pulse before such a run separates the eighth forced start from the ninth. Random cycles then mix trips, both overcurrents, zero crossings, droop and override pulses. Every clock of those cycles is compared against a bench model built from the requirements, which exposes errors in priority order and in state carried across cycle starts.

// File: rtl/pwm_sw_pkg.sv
package pwm_sw_pkg;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_cmd_t;

  // clocks of high-side conduction allowed in a cycle of len clocks
  function automatic int unsigned duty_limit(input int unsigned len, input int unsigned pct);
    return (len * pct) / 100;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_duty_timer.sv
module pwm_duty_timer
  import pwm_sw_pkg::*;
#(
  parameter int unsigned LEN_FAST = 50,
  parameter int unsigned LEN_SLOW = 75,
  parameter int unsigned PCT_FAST = 94,
  parameter int unsigned PCT_SLOW = 96,
  parameter int unsigned CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             freq_fast,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             limit_hit_o
);
  localparam int unsigned LIM_FAST = duty_limit(LEN_FAST, PCT_FAST);
  localparam int unsigned LIM_SLOW = duty_limit(LEN_SLOW, PCT_SLOW);

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos_q <= '0;
    else if (cyc_start)        pos_q <= '0;
    else if (pos_q != '1)      pos_q <= pos_q + 1'b1;
  end

  assign lim_o       = freq_fast ? CNT_W'(LIM_FAST) : CNT_W'(LIM_SLOW);
  assign limit_hit_o = (pos_q >= lim_o);
  assign pos_o       = pos_q;

  // R4
  pos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (pos_o == '0));

endmodule

// File: rtl/pwm_skip_ctrl.sv
module pwm_skip_ctrl #(
  parameter bit          AUX_EXIT     = 1'b1,
  parameter int unsigned FORCE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic psave_n,
  input  logic light_load,
  input  logic fb_low,
  input  logic aux_droop,
  output logic fire_o,
  output logic skip_o,
  output logic forced_o,
  output logic zc_cut_en_o
);
  localparam int unsigned FW = $clog2(FORCE_CYCLES + 1);

  logic          skip_q;
  logic [FW-1:0] force_cnt;
  logic          allow;

  generate
    if (AUX_EXIT) begin : g_aux_exit
      logic [FW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (aux_droop)                   cnt_q <= FW'(FORCE_CYCLES);
        else if (cyc_start && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign force_cnt = cnt_q;
    end else begin : g_no_aux_exit
      assign force_cnt = '0;
    end
  endgenerate

  assign forced_o    = (force_cnt != '0);
  assign allow       = !psave_n && !forced_o;
  assign zc_cut_en_o = allow;

  always_comb begin
    fire_o = 1'b1;
    if (allow && skip_q) fire_o = fb_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else if (cyc_start) begin
      if (!allow)                    skip_q <= 1'b0;
      else if (!skip_q)              skip_q <= light_load;
      else if (fb_low && !light_load) skip_q <= 1'b0;
    end
  end

  assign skip_o = skip_q;

  // R9
  forced_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && forced_o) |=> !skip_o);

  // R8
  skip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !psave_n && !forced_o && light_load) |=> skip_o);

endmodule

// File: rtl/pwm_switch_logic.sv
module pwm_switch_logic
  import pwm_sw_pkg::*;
#(
  parameter int unsigned LEN_FAST     = 50,
  parameter int unsigned LEN_SLOW     = 75,
  parameter int unsigned PCT_FAST     = 94,
  parameter int unsigned PCT_SLOW     = 96,
  parameter bit          AUX_EXIT     = 1'b1,
  parameter int unsigned FORCE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic freq_fast,
  input  logic cmp_trip,
  input  logic oc_pos,
  input  logic oc_neg,
  input  logic zero_cross,
  input  logic light_load,
  input  logic fb_low,
  input  logic phase_low,
  input  logic lg_low,
  input  logic psave_n,
  input  logic aux_droop,
  input  logic ovp_force,
  input  logic halt,
  output logic hs_on,
  output logic ls_on,
  output logic skip_mode
);
  localparam int unsigned LEN_MAX = max_u(LEN_FAST, LEN_SLOW);
  localparam int unsigned CNT_W   = $clog2(LEN_MAX + 2);

  logic [CNT_W-1:0] pos, lim;
  logic             limit_hit, fire, forced, zc_cut_en;

  pwm_duty_timer #(
    .LEN_FAST(LEN_FAST), .LEN_SLOW(LEN_SLOW),
    .PCT_FAST(PCT_FAST), .PCT_SLOW(PCT_SLOW), .CNT_W(CNT_W)
  ) duty_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .freq_fast(freq_fast),
    .pos_o(pos), .lim_o(lim), .limit_hit_o(limit_hit)
  );

  pwm_skip_ctrl #(.AUX_EXIT(AUX_EXIT), .FORCE_CYCLES(FORCE_CYCLES)) skip_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .psave_n(psave_n),
    .light_load(light_load), .fb_low(fb_low), .aux_droop(aux_droop),
    .fire_o(fire), .skip_o(skip_mode), .forced_o(forced), .zc_cut_en_o(zc_cut_en)
  );

  gate_cmd_t g_q, g_n;
  logic      req_q, req_n;   // high-side turn-on pending this cycle
  logic      arm_q, arm_n;   // low-side may start this cycle

  // named events
  logic ev_end_req, ev_hs_start, ev_req_cancel, ev_hs_end, ev_ls_start, ev_ls_cut;
  assign ev_end_req    = cmp_trip | oc_pos | limit_hit;
  assign ev_req_cancel = req_q && ev_end_req;
  assign ev_hs_start   = req_q && !ev_end_req && lg_low && !g_q.ls;
  assign ev_hs_end     = g_q.hs && ev_end_req;
  assign ev_ls_start   = arm_q && phase_low && !g_q.hs;
  assign ev_ls_cut     = g_q.ls && (oc_neg || (zc_cut_en && zero_cross));

  always_comb begin
    g_n   = g_q;
    req_n = req_q;
    arm_n = arm_q;
    if (halt) begin
      g_n = '0; req_n = 1'b0; arm_n = 1'b0;
    end else if (ovp_force) begin
      g_n.hs = 1'b0; g_n.ls = 1'b1; req_n = 1'b0; arm_n = 1'b0;
    end else if (cyc_start) begin
      g_n = '0; req_n = fire; arm_n = 1'b0;
    end else begin
      if (ev_req_cancel) begin req_n = 1'b0; arm_n = 1'b1; end
      else if (ev_hs_start) begin req_n = 1'b0; g_n.hs = 1'b1; end
      if (ev_hs_end) begin g_n.hs = 1'b0; arm_n = 1'b1; end
      if (ev_ls_start) begin g_n.ls = 1'b1; arm_n = 1'b0; end
      if (ev_ls_cut) g_n.ls = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q <= '0; req_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      g_q <= g_n; req_q <= req_n; arm_q <= arm_n;
    end
  end

  assign hs_on = g_q.hs;
  assign ls_on = g_q.ls;

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  // R2
  hs_after_lg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> ($past(lg_low) && !$past(ls_on)));

  // R3
  hs_trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && (cmp_trip || oc_pos)) |=> !hs_on);

  // R4
  duty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |-> (pos <= lim));

  // R5
  ls_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_on) && !$past(ovp_force)) |-> $past(phase_low));

  // R6
  ls_neg_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && oc_neg && !ovp_force) |=> !ls_on);

  // R10
  ovp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_force && !halt) |=> (!hs_on && ls_on));

  // R11
  halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!hs_on && !ls_on));

endmodule

// File: tb/pwm_switch_logic_tb.sv
module pwm_switch_logic_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 0, freq_fast = 1, cmp_trip = 0, oc_pos = 0, oc_neg = 0;
  logic zero_cross = 0, light_load = 0, fb_low = 0, phase_low = 0, lg_low = 0;
  logic psave_n = 1, aux_droop = 0, ovp_force = 0, halt = 0;
  logic hs_on, ls_on, skip_mode;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_switch_logic dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .freq_fast(freq_fast),
    .cmp_trip(cmp_trip), .oc_pos(oc_pos), .oc_neg(oc_neg), .zero_cross(zero_cross),
    .light_load(light_load), .fb_low(fb_low), .phase_low(phase_low), .lg_low(lg_low),
    .psave_n(psave_n), .aux_droop(aux_droop), .ovp_force(ovp_force), .halt(halt),
    .hs_on(hs_on), .ls_on(ls_on), .skip_mode(skip_mode)
  );

  // reference model state
  logic m_hs, m_ls, m_skip, m_req, m_arm;
  int   m_pos, m_cnt;

  function automatic int lim_of(input logic fast);
    return fast ? 50*94/100 : 75*96/100;
  endfunction

  task automatic mstep();
    logic allow, fire, endreq, hs, ls, req, arm, sk;
    if (!rst_n) begin
      m_hs = 0; m_ls = 0; m_skip = 0; m_req = 0; m_arm = 0; m_pos = 0; m_cnt = 0;
      return;
    end
    allow  = !psave_n && (m_cnt == 0);
    endreq = cmp_trip || oc_pos || (m_pos >= lim_of(freq_fast));
    fire = 1; sk = m_skip;
    if (cyc_start) begin
      if (!allow) sk = 0;
      else if (!m_skip) sk = light_load;
      else begin fire = fb_low; if (fb_low && !light_load) sk = 0; end
    end
    hs = m_hs; ls = m_ls; req = m_req; arm = m_arm;
    if (halt) begin hs = 0; ls = 0; req = 0; arm = 0; end
    else if (ovp_force) begin hs = 0; ls = 1; req = 0; arm = 0; end
    else if (cyc_start) begin hs = 0; ls = 0; req = fire; arm = 0; end
    else begin
      if (m_req && endreq) begin req = 0; arm = 1; end
      else if (m_req && lg_low && !m_ls) begin req = 0; hs = 1; end
      if (m_hs && endreq) begin hs = 0; arm = 1; end
      if (m_arm && phase_low && !m_hs) begin ls = 1; arm = 0; end
      if (m_ls && (oc_neg || (allow && zero_cross))) ls = 0;
    end
    m_cnt = aux_droop ? 8 : ((cyc_start && m_cnt > 0) ? m_cnt - 1 : m_cnt);
    m_pos = cyc_start ? 0 : ((m_pos < 255) ? m_pos + 1 : m_pos);
    m_hs = hs; m_ls = ls; m_req = req; m_arm = arm; m_skip = sk;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model update, then compare all outputs against model
  task automatic clk1();
    @(posedge clk);
    mstep();
    #1;
    chk("R3/hs model", hs_on, m_hs);
    chk("R5/ls model", ls_on, m_ls);
    chk("R8/skip model", skip_mode, m_skip);
  endtask

  task automatic start_tick();
    cyc_start = 1; clk1(); cyc_start = 0;
  endtask

  task automatic idle_inputs();
    cmp_trip = 0; oc_pos = 0; oc_neg = 0; zero_cross = 0; aux_droop = 0;
    ovp_force = 0; halt = 0; phase_low = 0; lg_low = 1;
  endtask

  // a short cycle: start, high side on, trip after 3, low side on, rest
  task automatic short_cycle(input int len);
    start_tick();
    for (int i = 1; i < len; i++) begin
      cmp_trip  = (i == 3);
      phase_low = (i >= 4);
      clk1();
    end
    cmp_trip = 0; phase_low = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hcount;
    logic seen;
    void'($urandom(32'd20240611));
    idle_inputs();
    clk1(); clk1();
    chk("R1 hs reset", hs_on, 1'b0);
    chk("R1 ls reset", ls_on, 1'b0);
    chk("R1 skip reset", skip_mode, 1'b0);
    #2 rst_n = 1;
    clk1();

    // R2: hold low gate not-discharged, high side must wait
    lg_low = 0; start_tick();
    clk1(); clk1(); clk1();
    chk("R2 hs waits for lg_low", hs_on, 1'b0);
    lg_low = 1; clk1();
    chk("R2 hs on after lg_low", hs_on, 1'b1);
    // R3: comparator trip ends pulse next edge
    cmp_trip = 1; clk1(); cmp_trip = 0;
    chk("R3 hs off after trip", hs_on, 1'b0);
    // R5: low side waits for phase node
    clk1(); clk1();
    chk("R5 ls waits for phase_low", ls_on, 1'b0);
    phase_low = 1; clk1();
    chk("R5 ls on after phase_low", ls_on, 1'b1);
    clk1(); clk1();
    chk("R5 ls held", ls_on, 1'b1);
    // R6: negative overcurrent cuts low side for rest of cycle
    oc_neg = 1; clk1(); oc_neg = 0;
    chk("R6 ls off on oc_neg", ls_on, 1'b0);
    clk1(); clk1();
    chk("R6 ls stays off", ls_on, 1'b0);
    phase_low = 0;
    // R3: positive overcurrent
    start_tick(); clk1();
    chk("R2 hs on", hs_on, 1'b1);
    oc_pos = 1; clk1(); oc_pos = 0;
    chk("R3 hs off on oc_pos", hs_on, 1'b0);
    phase_low = 1; clk1(); clk1();
    // R7: zero cross ignored with skipping disallowed
    psave_n = 1; zero_cross = 1; clk1(); zero_cross = 0;
    chk("R7 zero_cross ignored", ls_on, 1'b1);
    psave_n = 0; zero_cross = 1; clk1(); zero_cross = 0;
    chk("R7 zero_cross cuts ls", ls_on, 1'b0);
    start_tick();
    chk("R5 ls off at cycle start", ls_on, 1'b0);
    phase_low = 0; psave_n = 1;
    for (int i = 0; i < 6; i++) clk1();

    // R4: duty limit at each setting, no trip
    for (int f = 0; f < 2; f++) begin
      freq_fast = (f == 0);
      start_tick();
      hcount = 0;
      for (int i = 1; i < (freq_fast ? 50 : 75); i++) begin
        clk1();
        if (hs_on) hcount++;
      end
      n_run++;
      if (hcount != (freq_fast ? 47 : 72)) begin
        n_fail++;
        $display("FAIL R4 pulse clocks actual=%0d expected=%0d", hcount, freq_fast ? 47 : 72);
      end
    end
    freq_fast = 1;

    // R8: entering, skipping, exiting
    psave_n = 0; light_load = 1; fb_low = 0;
    start_tick(); clk1();
    chk("R8 entry cycle still fires", hs_on, 1'b1);
    chk("R8 skip set", skip_mode, 1'b1);
    for (int i = 0; i < 8; i++) clk1();
    start_tick(); clk1(); clk1();
    chk("R8 skipped cycle no pulse", hs_on, 1'b0);
    for (int i = 0; i < 8; i++) clk1();
    fb_low = 1;
    start_tick(); clk1();
    chk("R8 fires on fb_low", hs_on, 1'b1);
    chk("R8 stays skipping at light load", skip_mode, 1'b1);
    for (int i = 0; i < 8; i++) clk1();
    light_load = 0;
    start_tick();
    chk("R8 exit on heavier load", skip_mode, 1'b0);
    for (int i = 0; i < 9; i++) clk1();
    psave_n = 1; start_tick();
    chk("R8 psave disabled clears skip", skip_mode, 1'b0);
    for (int i = 0; i < 9; i++) clk1();

    // R9: droop forces 8 starts without skipping
    psave_n = 0; light_load = 1; fb_low = 0;
    aux_droop = 1; clk1(); aux_droop = 0;
    for (int c = 0; c < 8; c++) begin
      start_tick(); clk1();
      chk("R9 forced cycle fires", hs_on, 1'b1);
      chk("R9 no skip while forced", skip_mode, 1'b0);
      for (int i = 0; i < 6; i++) clk1();
    end
    start_tick();
    chk("R9 skip after forced window", skip_mode, 1'b1);
    for (int i = 0; i < 8; i++) clk1();
    psave_n = 1; light_load = 0;

    // R10 / R11: overrides
    short_cycle(10);
    start_tick(); clk1();
    ovp_force = 1; clk1();
    chk("R10 ovp hs off", hs_on, 1'b0);
    chk("R10 ovp ls on", ls_on, 1'b1);
    halt = 1; clk1();
    chk("R11 halt hs off", hs_on, 1'b0);
    chk("R11 halt beats ovp", ls_on, 1'b0);
    halt = 0; ovp_force = 0;
    for (int i = 0; i < 4; i++) clk1();

    // random cycles against model
    for (int c = 0; c < 70; c++) begin
      int len;
      freq_fast  = $urandom % 2;
      len        = freq_fast ? 50 : 75;
      psave_n    = ($urandom % 3 == 0);
      light_load = $urandom % 2;
      fb_low     = $urandom % 2;
      seen = 0;
      start_tick();
      for (int i = 1; i < len; i++) begin
        cmp_trip   = ($urandom % 25 == 0);
        oc_pos     = ($urandom % 80 == 0);
        oc_neg     = ($urandom % 40 == 0);
        zero_cross = ($urandom % 30 == 0);
        phase_low  = ($urandom % 3 != 0);
        lg_low     = !ls_on && ($urandom % 4 != 0);
        aux_droop  = ($urandom % 400 == 0);
        ovp_force  = ($urandom % 600 == 0);
        halt       = ($urandom % 700 == 0);
        clk1();
        if (hs_on && ls_on) seen = 1;
      end
      chk("R12 no overlap", seen, 1'b0);
      idle_inputs();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule